// File: doc/BRIEF.md
# Programmable IO Address Window Decoder

This block routes each physical address it is given to a target ID. Software programs a bank of address windows through a 32-bit register port. Each window has a lower bound, an upper bound and a target ID. Both bounds have 1 MB granularity. A lookup address that falls inside an enabled window returns that window's target and raises a hit flag. An address that matches no enabled window returns a programmable default target with the hit flag low.

The bounds are stored as address bits [47:20] in bits [31:4] of their registers, and both bounds are inclusive. The upper bound therefore covers the whole last megabyte it names. Window 0 is meant for boot code and is the only window that comes out of reset already enabled. Software normally fills windows from index 1 upwards. The lookup result is registered, and the register port returns read data one clock after a read strobe.

Top module: `iowin_decoder`

## Requirements
- R1: Out of reset, window 0 has start register 0x00000001 (enabled, base unit 0), end register 0x000000F0 (units 0 to 15) and target 1. Every other window register and the default-target register read zero.
- R2: Register map:
  - Window n occupies byte offsets 0x10*n to 0x10*n+0xF, with start at +0x0, end at +0x8 and target at +0xC. The default target sits at 0x100.
  - The start register keeps bits [31:4] (the base unit) and bit 0 (enable), and bits [3:1] read zero.
  - The end register keeps bits [31:4], and bits [3:0] read zero.
  - The target and default registers keep bits [3:0], and the upper bits read zero.
  - Read data appears on the clock after the read strobe.
- R3: A window matches a lookup address only while its enable bit is 1 and address bits [47:20] are at least the start unit and at most the end unit. Both limits are inclusive, so every byte of the end unit hits.
- R4: When several enabled windows match, the lowest-numbered window supplies the target.
- R5: When no enabled window matches, the hit flag is 0 and the target equals bits [3:0] of the default register.
- R6: Writing a start register with bit 0 clear removes the window from decode, and its base unit still reads back unchanged.
- R7: The lookup hit flag and target are registered. They reflect the address present at the previous rising clock edge and do not change between edges.
- R8: Writes to unmapped offsets have no effect. This covers offsets +0x4 within a slot, slots at or beyond the window count, and offsets other than 0x100 above them. Reads of those offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, valid the cycle after cfg_rd |
| lk_addr | input | 48 | Physical address to decode |
| lk_target | output | 4 | Selected target ID, registered |
| lk_hit | output | 1 | High when an enabled window matched, registered |

## Verification
Both results are due exactly one rising edge after their stimulus. The bench drives an input on a falling edge and checks the output on the next falling edge. In the latency test it also samples just before the edge, to confirm that the old lookup result is still held. Register writes take effect at the edge where they are sampled, and the bench's reference model is updated only after that edge, so the next lookup is compared with the new window set.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  localparam int PA_W    = 48;
  localparam int GRAN_LG = 20;
  localparam int UNIT_W  = PA_W - GRAN_LG;
  localparam int TGT_W   = 4;
  localparam int REG_W   = 32;
  localparam int CFG_AW  = 12;

  localparam logic [3:0] OFS_START = 4'h0;
  localparam logic [3:0] OFS_END   = 4'h8;
  localparam logic [3:0] OFS_TGT   = 4'hC;

  typedef logic [UNIT_W-1:0] unit_t;
  typedef logic [TGT_W-1:0]  tgt_t;
endpackage

// File: rtl/iowin_regfile.sv
module iowin_regfile
  import iowin_pkg::*;
#(
  parameter int            NUM_WIN  = 16,
  parameter int            GCR_OFS  = 'h100,
  parameter logic [31:0]   W0_START = 32'h0000_0001,
  parameter logic [31:0]   W0_END   = 32'h0000_00F0,
  parameter logic [31:0]   W0_TGT   = 32'h0000_0001
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_wr,
  input  logic                 cfg_rd,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [REG_W-1:0]     cfg_wdata,
  output logic [REG_W-1:0]     cfg_rdata,
  output logic [NUM_WIN-1:0]   win_en,
  output unit_t                win_lo  [NUM_WIN],
  output unit_t                win_hi  [NUM_WIN],
  output tgt_t                 win_tgt [NUM_WIN],
  output tgt_t                 dflt_tgt
);
  localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam int SLOT_W = CFG_AW - 4;

  logic [SLOT_W-1:0] slot;
  logic [3:0]        sub;
  logic [IDX_W-1:0]  idx;
  logic              in_win;
  logic              is_gcr;
  logic [REG_W-1:0]  rd_mux;

  assign slot   = cfg_addr[CFG_AW-1:4];
  assign sub    = cfg_addr[3:0];
  assign idx    = slot[IDX_W-1:0];
  assign in_win = (slot < SLOT_W'(NUM_WIN));
  assign is_gcr = (cfg_addr == CFG_AW'(GCR_OFS));

  // Per-window storage; window 0 carries the boot reset values
  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        win_en[i]  <= (i == 0) ? W0_START[0]          : 1'b0;
        win_lo[i]  <= (i == 0) ? W0_START[REG_W-1:4]  : '0;
        win_hi[i]  <= (i == 0) ? W0_END[REG_W-1:4]    : '0;
        win_tgt[i] <= (i == 0) ? W0_TGT[TGT_W-1:0]    : '0;
      end else if (cfg_wr && in_win && (idx == IDX_W'(i))) begin
        case (sub)
          OFS_START: begin
            win_lo[i] <= cfg_wdata[REG_W-1:4];
            win_en[i] <= cfg_wdata[0];
          end
          OFS_END: win_hi[i]  <= cfg_wdata[REG_W-1:4];
          OFS_TGT: win_tgt[i] <= cfg_wdata[TGT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   dflt_tgt <= '0;
    else if (cfg_wr && is_gcr) dflt_tgt <= cfg_wdata[TGT_W-1:0];
  end

  always_comb begin
    rd_mux = '0;
    if (in_win) begin
      case (sub)
        OFS_START: rd_mux = {win_lo[idx], 3'b000, win_en[idx]};
        OFS_END:   rd_mux = {win_hi[idx], 4'b0000};
        OFS_TGT:   rd_mux = {{(REG_W-TGT_W){1'b0}}, win_tgt[idx]};
        default:   rd_mux = '0;
      endcase
    end else if (is_gcr) begin
      rd_mux = {{(REG_W-TGT_W){1'b0}}, dflt_tgt};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= rd_mux;
  end

  // R2: padding bits of a start-register read are zero
  assert_pad_zero_R2: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_rd && in_win && (sub == OFS_START)) |-> (cfg_rdata[3:1] == 3'b000));

  // R8: unmapped offsets read as zero
  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_rd && !in_win && !is_gcr) |-> (cfg_rdata == '0));
endmodule

// File: rtl/iowin_match.sv
module iowin_match
  import iowin_pkg::*;
#(
  parameter int NUM_WIN = 16
) (
  input  unit_t                lk_unit,
  input  logic [NUM_WIN-1:0]   win_en,
  input  unit_t                win_lo [NUM_WIN],
  input  unit_t                win_hi [NUM_WIN],
  output logic [NUM_WIN-1:0]   hit_vec
);
  // One inclusive range comparator pair per window
  for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
    logic ge_lo, le_hi;
    assign ge_lo      = (lk_unit >= win_lo[i]);
    assign le_hi      = (lk_unit <= win_hi[i]);
    assign hit_vec[i] = win_en[i] & ge_lo & le_hi;
  end
endmodule

// File: rtl/iowin_select.sv
module iowin_select
  import iowin_pkg::*;
#(
  parameter int NUM_WIN = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WIN-1:0]   hit_vec,
  input  tgt_t                 win_tgt [NUM_WIN],
  input  tgt_t                 dflt_tgt,
  output logic                 lk_hit,
  output tgt_t                 lk_target
);
  logic [NUM_WIN-1:0] grant;
  tgt_t               sel_tgt;

  // Isolate the lowest set bit: lowest-numbered window has priority
  assign grant = hit_vec & (~hit_vec + NUM_WIN'(1));

  always_comb begin
    sel_tgt = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      sel_tgt |= grant[i] ? win_tgt[i] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit    <= 1'b0;
      lk_target <= '0;
    end else begin
      lk_hit    <= |hit_vec;
      lk_target <= (|hit_vec) ? sel_tgt : dflt_tgt;
    end
  end

  // R4: a granted window never has a lower-numbered matching window
  for (genvar i = 1; i < NUM_WIN; i++) begin : g_chk
    assert_lowest_wins_R4: assert property (@(posedge clk) disable iff (rst)
      grant[i] |-> (hit_vec[i-1:0] == '0));
  end
endmodule

// File: rtl/iowin_decoder.sv
module iowin_decoder
  import iowin_pkg::*;
#(
  parameter int          NUM_WIN  = 16,
  parameter int          GCR_OFS  = 'h100,
  parameter logic [31:0] W0_START = 32'h0000_0001,
  parameter logic [31:0] W0_END   = 32'h0000_00F0,
  parameter logic [31:0] W0_TGT   = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [11:0]       cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [47:0]       lk_addr,
  output logic [3:0]        lk_target,
  output logic              lk_hit
);
  logic [NUM_WIN-1:0] win_en;
  unit_t              win_lo  [NUM_WIN];
  unit_t              win_hi  [NUM_WIN];
  tgt_t               win_tgt [NUM_WIN];
  tgt_t               dflt_tgt;
  logic [NUM_WIN-1:0] hit_vec;
  unit_t              lk_unit;

  assign lk_unit = lk_addr[PA_W-1:GRAN_LG];

  iowin_regfile #(
    .NUM_WIN(NUM_WIN), .GCR_OFS(GCR_OFS),
    .W0_START(W0_START), .W0_END(W0_END), .W0_TGT(W0_TGT)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .win_en(win_en), .win_lo(win_lo), .win_hi(win_hi),
    .win_tgt(win_tgt), .dflt_tgt(dflt_tgt)
  );

  iowin_match #(.NUM_WIN(NUM_WIN)) u_match (
    .lk_unit(lk_unit), .win_en(win_en), .win_lo(win_lo),
    .win_hi(win_hi), .hit_vec(hit_vec)
  );

  iowin_select #(.NUM_WIN(NUM_WIN)) u_sel (
    .clk(clk), .rst(rst), .hit_vec(hit_vec), .win_tgt(win_tgt),
    .dflt_tgt(dflt_tgt), .lk_hit(lk_hit), .lk_target(lk_target)
  );

  // R5: a miss reports the default target held at the sampling edge
  assert_miss_default_R5: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_target == $past(dflt_tgt)));

  // R3: a hit is only possible while some window was enabled
  assert_hit_needs_enable_R3: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> $past(|win_en));
endmodule

// File: tb/sim_iowin_decoder.sv
module sim_iowin_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NW         = 16;
  localparam int WDOG       = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [47:0] lk_addr = '0;
  logic [3:0]  lk_target;
  logic        lk_hit;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  logic [31:0] m_st [NW];
  logic [31:0] m_en [NW];
  logic [31:0] m_tg [NW];
  logic [31:0] m_gcr;

  iowin_decoder u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .lk_addr(lk_addr), .lk_target(lk_target), .lk_hit(lk_hit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == WDOG && !done) begin
      errors++;
      $display("FAIL R7 watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [11:0] a);
    int s = int'(a[11:4]);
    if (s < NW) begin
      case (a[3:0])
        4'h0: return m_st[s];
        4'h8: return m_en[s];
        4'hC: return m_tg[s];
        default: return 32'h0;
      endcase
    end
    if (a == 12'h100) return m_gcr;
    return 32'h0;
  endfunction

  function automatic void m_write(input logic [11:0] a, input logic [31:0] d);
    int s = int'(a[11:4]);
    if (s < NW) begin
      case (a[3:0])
        4'h0: m_st[s] = d & 32'hFFFF_FFF1;
        4'h8: m_en[s] = d & 32'hFFFF_FFF0;
        4'hC: m_tg[s] = d & 32'h0000_000F;
        default: ;
      endcase
    end else if (a == 12'h100) m_gcr = d & 32'hF;
  endfunction

  task automatic m_lookup(input logic [47:0] a, output bit h, output logic [3:0] t);
    logic [27:0] u = a[47:20];
    h = 1'b0; t = m_gcr[3:0];
    for (int i = 0; i < NW; i++) begin
      if (!h && m_st[i][0] && u >= m_st[i][31:4] && u <= m_en[i][31:4]) begin
        h = 1'b1; t = m_tg[i][3:0];
      end
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    m_write(a, d);
  endtask

  task automatic rd_chk(input logic [11:0] a, input string req);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    chk(cfg_rdata == m_read(a), req, $sformatf("read @%0h", a), 64'(cfg_rdata), 64'(m_read(a)));
  endtask

  task automatic lk_chk(input logic [47:0] a, input string req);
    bit eh; logic [3:0] et;
    @(negedge clk);
    lk_addr = a;
    m_lookup(a, eh, et);
    @(negedge clk);
    chk(lk_hit == eh && lk_target == et, req, $sformatf("lookup %0h {hit,tgt}", a),
        64'({lk_hit, lk_target}), 64'({eh, et}));
  endtask

  initial begin
    bit eh; logic [3:0] et;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NW; i++) begin
      m_st[i] = '0; m_en[i] = '0; m_tg[i] = '0;
    end
    m_st[0] = 32'h0000_0001; m_en[0] = 32'h0000_00F0; m_tg[0] = 32'h1;
    m_gcr = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset contents
    rd_chk(12'h000, "R1"); rd_chk(12'h008, "R1"); rd_chk(12'h00C, "R1");
    rd_chk(12'h050, "R1"); rd_chk(12'h058, "R1"); rd_chk(12'h100, "R1");
    lk_chk(48'h0000_00FF_FFFF, "R1");
    lk_chk(48'h0000_0100_0000, "R1");

    // R2: field masking and map
    wr(12'h030, 32'hFFFF_FFFF); rd_chk(12'h030, "R2");
    wr(12'h038, 32'hFFFF_FFFF); rd_chk(12'h038, "R2");
    wr(12'h03C, 32'hFFFF_FFFF); rd_chk(12'h03C, "R2");
    wr(12'h100, 32'hFFFF_FFF7); rd_chk(12'h100, "R2");
    wr(12'h030, 32'h0); wr(12'h038, 32'h0); wr(12'h03C, 32'h0);
    wr(12'h100, 32'hA);

    // R3: inclusive bounds, window 2 units 0x100..0x1FF
    wr(12'h028, 32'h0000_1FF0); wr(12'h02C, 32'h5); wr(12'h020, 32'h0000_1001);
    lk_chk(48'h0000_1000_0000, "R3");
    lk_chk(48'h0000_1FFF_FFFF, "R3");
    lk_chk(48'h0000_0FFF_FFFF, "R5");
    lk_chk(48'h0000_2000_0000, "R5");

    // R4: priority among overlapping windows
    wr(12'h048, 32'h0000_2800); wr(12'h04C, 32'h9); wr(12'h040, 32'h0000_1801);
    lk_chk(48'h0000_1C00_1234, "R4");
    lk_chk(48'h0000_2400_0000, "R4");
    wr(12'h018, 32'h0000_0080); wr(12'h01C, 32'h3); wr(12'h010, 32'h0000_0081);
    lk_chk(48'h0000_0080_0000, "R4");
    wr(12'h078, 32'hFFFF_FFF0); wr(12'h07C, 32'hC); wr(12'h070, 32'hFFFF_FFF1);
    lk_chk(48'hFFFF_FFFF_FFFF, "R3");

    // R6: disable keeps base
    wr(12'h020, 32'h0000_1000);
    rd_chk(12'h020, "R6");
    lk_chk(48'h0000_1C00_0000, "R6");
    lk_chk(48'h0000_1000_0000, "R6");

    // R8: unmapped offsets
    wr(12'h024, 32'hFFFF_FFFF); rd_chk(12'h024, "R8");
    wr(12'h104, 32'hFFFF_FFFF); rd_chk(12'h104, "R8");
    wr(12'h200, 32'hFFFF_FFF1); rd_chk(12'h200, "R8");
    rd_chk(12'h020, "R8");
    lk_chk(48'h0000_1000_0000, "R8");

    // R7: result held until the next edge, then updates
    lk_chk(48'h0000_1C00_0000, "R7");
    @(negedge clk);
    lk_addr = 48'h0000_0100_0000;
    m_lookup(lk_addr, eh, et);
    #1;
    chk(lk_hit == 1'b1 && lk_target == 4'h9, "R7", "held before edge",
        64'({lk_hit, lk_target}), 64'({1'b1, 4'h9}));
    @(negedge clk);
    chk(lk_hit == eh && lk_target == et, "R7", "after edge",
        64'({lk_hit, lk_target}), 64'({eh, et}));

    // Random mix (R3, R4, R5)
    for (int n = 0; n < 600; n++) begin
      int w = 1 + int'($urandom % (NW - 1));
      int k = int'($urandom % 6);
      logic [27:0] u = 28'($urandom % 256);
      if (k == 0)      wr(12'(w * 16),     {u, 3'($urandom), 1'($urandom)});
      else if (k == 1) wr(12'(w * 16 + 8), {u + 28'($urandom % 32), 4'($urandom)});
      else if (k == 2) wr(12'(w * 16 + 12), $urandom);
      else             lk_chk({28'($urandom % 300), 20'($urandom)}, "R4");
    end
    for (int n = 0; n < 40; n++) rd_chk(12'(($urandom % 17) * 16 + 4 * ($urandom % 4)), "R2");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule